// File: doc/BRIEF.md
# I2C Write-Only Control Register Slave

This block is a receive-only I2C target that gives a host write access to a small bank of 8-bit control registers. It watches oversampled SCL and SDA lines on its own system clock, recognises start and stop conditions, and checks that the first byte after a start carries its 7-bit device address with the write direction. It then takes the next byte as a register index. Every data byte after that goes to the indexed register, and the index advances by one after each byte.

The slave acknowledges a byte by pulling SDA low during the ninth clock. It withholds that acknowledge for a foreign address, a read request, an index outside the bank, or a data byte that would fall past the last register. After any refusal it ignores the bus until the next start condition. The whole register bank is presented in parallel to the datapath. Bits that a register does not implement always read as zero.

Top module: `i2c_wreg_slave`

## Requirements
- R1: After reset every register holds zero, except index 0x03, which holds 0x37. The SDA pull-down is inactive.
- R2: A byte 0x82 right after a start (address 7'b1000001 in bits 7:1, write flag 0 in bit 0) is acknowledged. The pull-down is asserted only after an SCL falling edge.
- R3: An address byte whose upper seven bits differ from 7'b1000001 is not acknowledged, and the transfer changes no register.
- R4: An address byte with bit 0 set (a read request) is not acknowledged, and no register changes.
- R5: An index byte of 0x10 or above is not acknowledged, and the data that follows is not written.
- R6: A data byte following an acknowledged index is written to that register, and each written byte is acknowledged.
- R7: Each further data byte in the same transfer goes to the next index up.
- R8: Bits a register does not implement are stored as zero. Index 0x00 keeps only bits 4:0, index 0x0B keeps only bits 6:0, and every other register keeps all 8 bits.
- R9: A data byte that would go past index 0x0F is not acknowledged and not written. After any refusal, or after a stop, bytes are ignored until the next start. A stop releases the pull-down.
- R10: A repeated start discards the transfer in progress, and the next byte must again be a valid address byte.
- R11: The pull-down does not change while SCL stays high, except in response to a start or a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8 times the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_pd_o | output | 1 | Enable for the open-drain pull-down on SDA |
| regs_o | output | 128 | Register bank; index i occupies bits 8i+7 to 8i |

## Verification
The assertions rely on a well-formed bus. SDA may change only while SCL is low, except at start and stop conditions, and each SCL level lasts several system clocks so that every edge passes the synchronizers as one clean transition. The bench holds each quarter of an SCL bit for ten system clocks. It changes its own SDA drive only during the low quarters, and models the wired-AND bus by combining its drive with the slave's pull-down. Repeated starts are issued from the SCL-low state after an acknowledge slot, which keeps them within these rules.

// File: rtl/i2c_wreg_pkg.sv
package i2c_wreg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SUB,
    PH_DATA
  } phase_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [2:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= 3'b111;
    else         pipe_q <= {pipe_q[1:0], line_i};
  end

  assign lvl_o  = pipe_q[1];
  assign rise_o = pipe_q[1] & ~pipe_q[2];
  assign fall_o = ~pipe_q[1] & pipe_q[2];
endmodule

// File: rtl/i2c_wreg_fsm.sv
module i2c_wreg_fsm
  import i2c_wreg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000001,
  parameter int         NUM_REGS = 16,
  localparam int        AW       = $clog2(NUM_REGS),
  localparam int        PTR_W    = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_lvl_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             sda_pd_o,
  output logic             we_o,
  output logic [AW-1:0]    waddr_o,
  output logic [7:0]       wdata_o,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [7:0]       NREG8 = 8'(NUM_REGS);
  localparam logic [PTR_W-1:0] NREGP = PTR_W'(NUM_REGS);

  phase_e           phase_q;
  logic [3:0]       bit_cnt_q;
  logic [7:0]       shreg_q;
  logic             ack_slot_q;
  logic             accept;
  phase_e           next_ph;

  always_comb begin
    accept  = 1'b0;
    next_ph = PH_IDLE;
    unique case (phase_q)
      PH_ADDR: begin accept = (shreg_q == {DEV_ADDR, 1'b0}); next_ph = PH_SUB;  end
      PH_SUB:  begin accept = (shreg_q < NREG8);             next_ph = PH_DATA; end
      PH_DATA: begin accept = (ptr_o < NREGP);               next_ph = PH_DATA; end
      default: begin accept = 1'b0;                          next_ph = PH_IDLE; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      bit_cnt_q  <= '0;
      shreg_q    <= '0;
      ack_slot_q <= 1'b0;
      sda_pd_o   <= 1'b0;
      we_o       <= 1'b0;
      waddr_o    <= '0;
      wdata_o    <= '0;
      ptr_o      <= '0;
    end else begin
      we_o <= 1'b0;
      if (start_i) begin
        phase_q    <= PH_ADDR;
        bit_cnt_q  <= '0;
        ack_slot_q <= 1'b0;
        sda_pd_o   <= 1'b0;
      end else if (stop_i) begin
        phase_q    <= PH_IDLE;
        bit_cnt_q  <= '0;
        ack_slot_q <= 1'b0;
        sda_pd_o   <= 1'b0;
      end else if (phase_q != PH_IDLE) begin
        if (scl_rise_i && !ack_slot_q && bit_cnt_q < 4'd8) begin
          shreg_q   <= {shreg_q[6:0], sda_lvl_i};
          bit_cnt_q <= bit_cnt_q + 4'd1;
        end else if (scl_fall_i) begin
          if (ack_slot_q) begin
            // end of acknowledge clock
            ack_slot_q <= 1'b0;
            sda_pd_o   <= 1'b0;
            bit_cnt_q  <= '0;
            phase_q    <= next_ph;
          end else if (bit_cnt_q == 4'd8) begin
            bit_cnt_q <= '0;
            if (accept) begin
              ack_slot_q <= 1'b1;
              sda_pd_o   <= 1'b1;
              if (phase_q == PH_SUB) ptr_o <= shreg_q[PTR_W-1:0];
              if (phase_q == PH_DATA) begin
                we_o    <= 1'b1;
                waddr_o <= ptr_o[AW-1:0];
                wdata_o <= shreg_q;
                ptr_o   <= ptr_o + 1'b1;
              end
            end else begin
              phase_q <= PH_IDLE;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_wreg_bank.sv
module i2c_wreg_bank #(
  parameter int                     NUM_REGS = 16,
  parameter logic [NUM_REGS*8-1:0]  RST_VAL  = '0,
  parameter logic [NUM_REGS*8-1:0]  WR_MASK  = '1,
  localparam int                    AW       = $clog2(NUM_REGS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [AW-1:0]         waddr_i,
  input  logic [7:0]            wdata_i,
  output logic [NUM_REGS*8-1:0] regs_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        regs_o[i*8 +: 8] <= RST_VAL[i*8 +: 8] & WR_MASK[i*8 +: 8];
      else if (we_i && waddr_i == AW'(i))
        regs_o[i*8 +: 8] <= wdata_i & WR_MASK[i*8 +: 8];
    end
  end
endmodule

// File: rtl/i2c_wreg_slave.sv
module i2c_wreg_slave #(
  parameter logic [6:0]             DEV_ADDR = 7'b1000001,
  parameter int                     NUM_REGS = 16,
  parameter logic [NUM_REGS*8-1:0]  RST_VAL  = {96'h0, 8'h37, 24'h0},
  parameter logic [NUM_REGS*8-1:0]  WR_MASK  = {32'hFFFF_FFFF, 8'h7F,
                                                80'hFFFF_FFFF_FFFF_FFFF_FFFF, 8'h1F}
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_pd_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int AW    = $clog2(NUM_REGS);
  localparam int PTR_W = AW + 1;

  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic start_det, stop_det;
  logic             wr_en;
  logic [AW-1:0]    wr_addr;
  logic [7:0]       wr_data;
  logic [PTR_W-1:0] wr_ptr;

  i2c_line_sync u_scl_sync (
    .clk_i, .rst_ni, .line_i(scl_i),
    .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
  );
  i2c_line_sync u_sda_sync (
    .clk_i, .rst_ni, .line_i(sda_i),
    .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  assign start_det = scl_lvl & sda_fall;
  assign stop_det  = scl_lvl & sda_rise;

  i2c_wreg_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_fsm (
    .clk_i, .rst_ni,
    .sda_lvl_i(sda_lvl), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .sda_pd_o, .we_o(wr_en), .waddr_o(wr_addr), .wdata_o(wr_data), .ptr_o(wr_ptr)
  );

  i2c_wreg_bank #(.NUM_REGS(NUM_REGS), .RST_VAL(RST_VAL), .WR_MASK(WR_MASK)) u_bank (
    .clk_i, .rst_ni, .we_i(wr_en), .waddr_i(wr_addr), .wdata_i(wr_data), .regs_o
  );
endmodule

// File: rtl/i2c_wreg_slave_chk.sv
module i2c_wreg_slave_chk #(
  parameter int NUM_REGS = 16,
  localparam int AW    = $clog2(NUM_REGS),
  localparam int PTR_W = AW + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sda_pd_o,
  input logic             scl_lvl,
  input logic             scl_fall,
  input logic             start_det,
  input logic             stop_det,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [PTR_W-1:0] wr_ptr
);
  // R2: acknowledge drive begins only after SCL falls
  a_r2_pd_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pd_o) |-> $past(scl_fall));

  // R6: a register write happens only on an acknowledged byte
  a_r6_write_acked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> sda_pd_o);

  // R7: index advances past the written register
  a_r7_ptr_incr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> wr_ptr == {1'b0, wr_addr} + 1'b1);

  // R9: stop releases SDA
  a_r9_stop_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_pd_o);

  // R11: SDA drive held steady across SCL high
  a_r11_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_lvl && $past(scl_lvl) && !$past(start_det) && !$past(stop_det))
      |-> $stable(sda_pd_o));
endmodule

bind i2c_wreg_slave i2c_wreg_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sda_pd_o(sda_pd_o),
  .scl_lvl(scl_lvl), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_ptr(wr_ptr)
);

// File: tb/i2c_wreg_slave_tb.sv
module i2c_wreg_slave_tb;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pd;
  logic [127:0] regs;
  logic sda_bus;

  assign sda_bus = sda_m & ~sda_pd;

  always #4 clk = ~clk;

  i2c_wreg_slave u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pd_o(sda_pd), .regs_o(regs)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] model [16];

  function automatic logic [7:0] mask_of(int i);
    if (i == 0)  return 8'h1F;
    if (i == 11) return 8'h7F;
    return 8'hFF;
  endfunction

  function automatic logic [127:0] model_vec();
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    model[3] = 8'h37;
  endtask

  task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq();
      scl_m = 1'b1; wq(); wq();
      scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    acked = (sda_bus == 1'b0);
    wq();
    scl_m = 1'b0; wq();
  endtask

  // {addr, index, data, ack_addr, ack_index, ack_data}
  localparam logic [26:0] VEC [8] = '{
    {8'h82, 8'h05, 8'hA5, 3'b111},   // R6
    {8'h82, 8'h00, 8'hFF, 3'b111},   // R8
    {8'h82, 8'h0B, 8'hFF, 3'b111},   // R8
    {8'h84, 8'h06, 8'h11, 3'b000},   // R3
    {8'h83, 8'h07, 8'h22, 3'b000},   // R4
    {8'h82, 8'h10, 8'h33, 3'b100},   // R5
    {8'h82, 8'h0F, 8'h44, 3'b111},   // R6
    {8'h82, 8'h03, 8'hC3, 3'b111}    // R6
  };
  localparam int VTAG [8] = '{6, 8, 8, 3, 4, 5, 6, 6};

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=hang exp=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a0, a1, a2, a3;
    model_reset();
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    wq();
    // R1 reset state
    check(regs == model_vec(), "R1 regs", regs, model_vec());
    check(sda_pd == 1'b0, "R1 pd", {127'h0, sda_pd}, 128'h0);

    // table walk: R2 R3 R4 R5 R6 R8
    for (int k = 0; k < 8; k++) begin
      bus_start();
      send_byte(VEC[k][26:19], a0);
      send_byte(VEC[k][18:11], a1);
      send_byte(VEC[k][10:3], a2);
      bus_stop();
      check({a0, a1, a2} == VEC[k][2:0], $sformatf("R%0d acks vec%0d", VTAG[k], k),
            {125'h0, a0, a1, a2}, {125'h0, VEC[k][2:0]});
      if (VEC[k][0]) model[VEC[k][14:11]] = VEC[k][10:3] & mask_of(int'(VEC[k][14:11]));
      check(regs == model_vec(), $sformatf("R%0d regs vec%0d", VTAG[k], k), regs, model_vec());
    end

    // R7 burst and R9 end of bank
    bus_start();
    send_byte(8'h82, a0);
    send_byte(8'h0D, a0);
    send_byte(8'h01, a1);
    send_byte(8'h02, a2);
    send_byte(8'h03, a3);
    check({a1, a2, a3} == 3'b111, "R7 burst acks", {125'h0, a1, a2, a3}, 128'h7);
    send_byte(8'h04, a0);
    bus_stop();
    check(a0 == 1'b0, "R9 past end ack", {127'h0, a0}, 128'h0);
    model[13] = 8'h01; model[14] = 8'h02; model[15] = 8'h03;
    check(regs == model_vec(), "R7 burst regs", regs, model_vec());

    // R9 bytes after stop without start are ignored
    send_byte(8'h82, a0);
    send_byte(8'h01, a1);
    send_byte(8'hEE, a2);
    check({a0, a1, a2} == 3'b000, "R9 no start acks", {125'h0, a0, a1, a2}, 128'h0);
    check(regs == model_vec(), "R9 no start regs", regs, model_vec());
    bus_stop();

    // R10 repeated start needs a fresh address
    bus_start();
    send_byte(8'h82, a0);
    send_byte(8'h02, a0);
    send_byte(8'h5A, a1);
    bus_start();
    send_byte(8'h02, a2);
    check(a1 == 1'b1 && a2 == 1'b0, "R10 rs addr", {126'h0, a1, a2}, 128'h2);
    bus_start();
    send_byte(8'h82, a0);
    send_byte(8'h04, a1);
    send_byte(8'h66, a2);
    bus_stop();
    check({a0, a1, a2} == 3'b111, "R10 rs acks", {125'h0, a0, a1, a2}, 128'h7);
    model[2] = 8'h5A; model[4] = 8'h66;
    check(regs == model_vec(), "R10 rs regs", regs, model_vec());
    check(sda_pd == 1'b0, "R9 released", {127'h0, sda_pd}, 128'h0);

    // R1 reset restores defaults
    rst_ni = 1'b0;
    wq();
    model_reset();
    check(regs == model_vec(), "R1 rereset", regs, model_vec());
    rst_ni = 1'b1;
    wq();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule